// File: doc/BRIEF.md
# PS/2 Key Matrix Emulator

This block turns a PS/2 keyboard byte stream into the state of a scanned key matrix of 16 columns by 8 rows. A host that expects a scanned matrix selects one column and one row and reads back whether that key is held. The host can also let the block step the column on its own from a 1 MHz enable. While it does so, the block drives an interrupt level whenever a key outside row 0 is down.

Incoming frames are synchronised, checked for framing and parity, and decoded. A release prefix and an extended prefix modify the code that follows them. Recognised codes set or clear one matrix bit, and unknown codes are ignored. One code drives a dedicated break output that does not touch the matrix. Eight configuration switches are overlaid on row 0, so they can be read like keys but never raise the interrupt.

Top module: `ps2_keymatrix`

## Requirements
- R1: After reset every matrix key reads released, `scan_col` is 0, and `intr` and `brk` are low.
- R2: A frame is 11 bits sampled on falling `ps2_clk` edges: a start bit of 0, 8 data bits LSB first, an odd parity bit, and a stop bit of 1. A valid code sets its key. The map used is: 0x12 to col 0 row 0; 0x14 to col 1 row 0; 0x15 to col 0 row 1; 0x26 to col 1 row 1; 0x25 to col 2 row 1; 0x1C to col 1 row 4; 0x1B to col 1 row 5; 0x29 to col 2 row 6; 0x5A to col 9 row 4; 0x76 to col 0 row 7; 0x05 to col 1 row 7; 0x66 to col 9 row 5.
- R3: A frame with wrong parity or a stop bit of 0 is discarded and changes no key.
- R4: A code preceded by the byte 0xF0 releases its key instead of setting it.
- R5: A code preceded by 0xE0 is looked up in the extended map: 0x75 to col 9 row 3 and 0x72 to col 9 row 2. Without the prefix these two codes are unmapped and ignored. A release of an extended key is E0 F0 code.
- R6: With `autoscan` low, `keypress` equals the state of the key at (`col_sel`, `row_sel`). With `autoscan` high, `keypress` is 0.
- R7: With `autoscan` high, `scan_col` increments on each cycle in which `tick_1mhz` is high and wraps from 15 to 0. With `autoscan` low, `scan_col` takes `col_sel` one cycle later.
- R8: `intr` is high exactly while at least one key in rows 1 to 7 is held. Keys in row 0 do not raise it.
- R9: Bit i of `dip_sw` reads at row 0, column 2+i through `keypress`, and never affects `intr`.
- R10: Code 0x07 (no prefix) sets `brk`, and F0 07 clears it. It changes no matrix key and does not affect `intr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ps2_clk | input | 1 | PS/2 clock line, asynchronous |
| ps2_dat | input | 1 | PS/2 data line, asynchronous |
| tick_1mhz | input | 1 | One-cycle enable that steps the autoscan column |
| autoscan | input | 1 | 1 selects self-stepping column mode |
| col_sel | input | 4 | Host column select |
| row_sel | input | 3 | Host row select |
| dip_sw | input | 8 | Configuration switches overlaid on row 0 |
| keypress | output | 1 | State of the selected key |
| intr | output | 1 | High while any key in rows 1 to 7 is held |
| brk | output | 1 | High while the break key is held |
| scan_col | output | 4 | Current column counter |

## Verification
A matrix or break change lands about five system cycles after the final falling PS/2 clock edge of a frame: two synchroniser stages, the edge register, the byte strobe and the map update. The bench therefore idles at least 30 cycles after each frame before it looks. `keypress` and `intr` are combinational views of registered state, so after a change of `col_sel`, `row_sel` or `dip_sw` the bench waits one full clock and samples on the falling edge. `scan_col` moves one clock after a tick or a column select, and the bench samples it on the falling edge that follows that rising edge.

// File: rtl/kmx_pkg.sv
package kmx_pkg;

    localparam int COL_W = 4;
    localparam int ROW_W = 3;
    localparam int NCOLS = 1 << COL_W;
    localparam int NROWS = 1 << ROW_W;
    localparam int MAP_BITS = NCOLS * NROWS;

    localparam logic [7:0] CODE_RELEASE = 8'hF0;
    localparam logic [7:0] CODE_EXTEND  = 8'hE0;
    localparam logic [7:0] CODE_BREAK   = 8'h07;

    typedef struct packed {
        logic             hit;
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
    } kpos_t;

    function automatic kpos_t mk(input int c, input int r);
        kpos_t p;
        p.hit = 1'b1;
        p.col = COL_W'(c);
        p.row = ROW_W'(r);
        return p;
    endfunction

    // Scan code (with extended flag) to matrix position
    function automatic kpos_t map_code(input logic ext, input logic [7:0] code);
        kpos_t p;
        p = '0;
        case ({ext, code})
            9'h012: p = mk(0, 0);
            9'h014: p = mk(1, 0);
            9'h015: p = mk(0, 1);
            9'h026: p = mk(1, 1);
            9'h025: p = mk(2, 1);
            9'h01C: p = mk(1, 4);
            9'h01B: p = mk(1, 5);
            9'h029: p = mk(2, 6);
            9'h05A: p = mk(9, 4);
            9'h076: p = mk(0, 7);
            9'h005: p = mk(1, 7);
            9'h066: p = mk(9, 5);
            9'h175: p = mk(9, 3);
            9'h172: p = mk(9, 2);
            default: p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/kmx_ps2_rx.sv
module kmx_ps2_rx #(
    parameter int SYNC_STAGES = 2,
    parameter int IDLE_LIMIT  = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ps2_clk,
    input  logic       ps2_dat,
    output logic [7:0] byte_o,
    output logic       byte_vld_o
);
    localparam int FRAME_BITS = 11;
    localparam int SH_W       = FRAME_BITS - 1;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam int IDLE_W     = $clog2(IDLE_LIMIT + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] cs;
        logic [SYNC_STAGES-1:0] ds;
        logic                   clk_prev;
        logic [SH_W-1:0]        sh;
        logic [CNT_W-1:0]       cnt;
        logic [IDLE_W-1:0]      idle;
        logic [7:0]             data;
        logic                   vld;
    } rx_t;

    rx_t rx_q, rx_d;
    logic clk_s, dat_s, fall;
    logic [FRAME_BITS-1:0] frame;

    always_comb begin
        rx_d     = rx_q;
        rx_d.vld = 1'b0;
        rx_d.cs  = {rx_q.cs[SYNC_STAGES-2:0], ps2_clk};
        rx_d.ds  = {rx_q.ds[SYNC_STAGES-2:0], ps2_dat};
        clk_s    = rx_q.cs[SYNC_STAGES-1];
        dat_s    = rx_q.ds[SYNC_STAGES-1];
        rx_d.clk_prev = clk_s;
        fall     = rx_q.clk_prev & ~clk_s;
        frame    = {dat_s, rx_q.sh};
        if (fall) begin
            rx_d.idle = '0;
            if (rx_q.cnt == '0 && dat_s) begin
                // line high where a start bit should be: stay idle
            end else if (rx_q.cnt == CNT_W'(FRAME_BITS - 1)) begin
                rx_d.cnt = '0;
                if (!frame[0] && frame[FRAME_BITS-1] && (^frame[9:1])) begin
                    rx_d.vld  = 1'b1;
                    rx_d.data = frame[8:1];
                end
            end else begin
                rx_d.sh  = {dat_s, rx_q.sh[SH_W-1:1]};
                rx_d.cnt = rx_q.cnt + 1'b1;
            end
        end else if (rx_q.cnt != '0) begin
            if (rx_q.idle == IDLE_W'(IDLE_LIMIT - 1)) begin
                rx_d.cnt  = '0;
                rx_d.idle = '0;
            end else begin
                rx_d.idle = rx_q.idle + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q          <= '0;
            rx_q.cs       <= '1;
            rx_q.ds       <= '1;
            rx_q.clk_prev <= 1'b1;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign byte_o     = rx_q.data;
    assign byte_vld_o = rx_q.vld;

    // R2: a byte strobe lasts one cycle only
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |=> !byte_vld_o);

endmodule

// File: rtl/kmx_decode.sv
module kmx_decode
    import kmx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          byte_i,
    input  logic                byte_vld_i,
    output logic [MAP_BITS-1:0] map_o,
    output logic                brk_o
);
    typedef struct packed {
        logic [MAP_BITS-1:0] map;
        logic                rel;
        logic                ext;
        logic                brk;
    } dec_t;

    dec_t dec_q, dec_d;
    kpos_t pos;
    logic [COL_W+ROW_W-1:0] idx;

    always_comb begin
        dec_d = dec_q;
        pos   = map_code(dec_q.ext, byte_i);
        idx   = {pos.col, pos.row};
        if (byte_vld_i) begin
            if (byte_i == CODE_RELEASE) begin
                dec_d.rel = 1'b1;
            end else if (byte_i == CODE_EXTEND) begin
                dec_d.ext = 1'b1;
            end else begin
                dec_d.rel = 1'b0;
                dec_d.ext = 1'b0;
                if (!dec_q.ext && byte_i == CODE_BREAK) begin
                    dec_d.brk = ~dec_q.rel;
                end else if (pos.hit) begin
                    dec_d.map[idx] = ~dec_q.rel;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign map_o = dec_q.map;
    assign brk_o = dec_q.brk;

    // R4: the release prefix is remembered for the next code
    a_r4_prefix_held: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && byte_i == CODE_RELEASE) |=> dec_q.rel);

    // R5: a final code consumes both prefixes
    a_r5_prefix_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && byte_i != CODE_RELEASE && byte_i != CODE_EXTEND)
        |=> (!dec_q.rel && !dec_q.ext));

    // R10: a released break code drops the break output
    a_r10_break_release: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && byte_i == CODE_BREAK && dec_q.rel && !dec_q.ext) |=> !brk_o);

    // R10: the break code leaves the matrix untouched
    a_r10_break_no_map: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && byte_i == CODE_BREAK && !dec_q.ext) |=> $stable(map_o));

endmodule

// File: rtl/kmx_scan.sv
module kmx_scan
    import kmx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             autoscan,
    input  logic             tick,
    input  logic [COL_W-1:0] col_sel,
    output logic [COL_W-1:0] scan_col
);
    typedef struct packed {
        logic [COL_W-1:0] col;
    } scan_t;

    scan_t scan_q, scan_d;

    always_comb begin
        scan_d = scan_q;
        if (!autoscan)  scan_d.col = col_sel;
        else if (tick)  scan_d.col = scan_q.col + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scan_q <= '0;
        else        scan_q <= scan_d;
    end

    assign scan_col = scan_q.col;

    // R7: one step per tick in autoscan mode
    a_r7_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (autoscan && tick) |=> scan_col == COL_W'($past(scan_col) + 1'b1));

    // R7: host column followed when autoscan is off
    a_r7_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !autoscan |=> scan_col == $past(col_sel));

endmodule

// File: rtl/ps2_keymatrix.sv
module ps2_keymatrix
    import kmx_pkg::*;
#(
    parameter int DIP_W       = 8,
    parameter int DIP_COL0    = 2,
    parameter int SYNC_STAGES = 2,
    parameter int IDLE_LIMIT  = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ps2_clk,
    input  logic             ps2_dat,
    input  logic             tick_1mhz,
    input  logic             autoscan,
    input  logic [COL_W-1:0] col_sel,
    input  logic [ROW_W-1:0] row_sel,
    input  logic [DIP_W-1:0] dip_sw,
    output logic             keypress,
    output logic             intr,
    output logic             brk,
    output logic [COL_W-1:0] scan_col
);
    localparam int HI_BITS = NCOLS * (NROWS - 1);

    logic [7:0]          rx_byte;
    logic                rx_vld;
    logic [MAP_BITS-1:0] key_map;
    logic [MAP_BITS-1:0] view;
    logic [HI_BITS-1:0]  keys_hi;

    kmx_ps2_rx #(
        .SYNC_STAGES(SYNC_STAGES),
        .IDLE_LIMIT (IDLE_LIMIT)
    ) i_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .ps2_clk    (ps2_clk),
        .ps2_dat    (ps2_dat),
        .byte_o     (rx_byte),
        .byte_vld_o (rx_vld)
    );

    kmx_decode i_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_i     (rx_byte),
        .byte_vld_i (rx_vld),
        .map_o      (key_map),
        .brk_o      (brk)
    );

    kmx_scan i_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .autoscan (autoscan),
        .tick     (tick_1mhz),
        .col_sel  (col_sel),
        .scan_col (scan_col)
    );

    // Matrix view with switches overlaid on row 0
    for (genvar c = 0; c < NCOLS; c++) begin : g_col
        for (genvar r = 0; r < NROWS; r++) begin : g_row
            if (r == 0 && c >= DIP_COL0 && c < DIP_COL0 + DIP_W) begin : g_dip
                assign view[c*NROWS + r] = dip_sw[c - DIP_COL0];
            end else begin : g_key
                assign view[c*NROWS + r] = key_map[c*NROWS + r];
            end
            if (r != 0) begin : g_hi
                assign keys_hi[c*(NROWS-1) + r - 1] = key_map[c*NROWS + r];
            end
        end
    end

    assign keypress = ~autoscan & view[{col_sel, row_sel}];
    assign intr     = |keys_hi;

    // R6: no key report while the column steps itself
    a_r6_autoscan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        autoscan |-> !keypress);

    // R9: switch movement alone never moves the interrupt
    a_r9_dip_no_intr: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_vld && !$stable(dip_sw)) |=> $stable(intr));

endmodule

// File: tb/test_ps2_keymatrix.sv
module test_ps2_keymatrix;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ps2_clk = 1'b1;
    logic       ps2_dat = 1'b1;
    logic       tick_1mhz = 1'b0;
    logic       autoscan = 1'b0;
    logic [3:0] col_sel = '0;
    logic [2:0] row_sel = '0;
    logic [7:0] dip_sw = '0;
    logic       keypress, intr, brk;
    logic [3:0] scan_col;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit model[16][8];
    bit model_brk = 1'b0;

    always #2.5 clk = ~clk;

    ps2_keymatrix i_ps2_keymatrix (
        .clk(clk), .rst_n(rst_n), .ps2_clk(ps2_clk), .ps2_dat(ps2_dat),
        .tick_1mhz(tick_1mhz), .autoscan(autoscan), .col_sel(col_sel),
        .row_sel(row_sel), .dip_sw(dip_sw), .keypress(keypress),
        .intr(intr), .brk(brk), .scan_col(scan_col)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Expected position per requirement R2 / R5 maps
    function automatic bit pos_of(input bit ext, input logic [7:0] code,
                                  output int c, output int r);
        c = 0; r = 0;
        case ({ext, code})
            9'h012: begin c = 0; r = 0; end
            9'h014: begin c = 1; r = 0; end
            9'h015: begin c = 0; r = 1; end
            9'h026: begin c = 1; r = 1; end
            9'h025: begin c = 2; r = 1; end
            9'h01C: begin c = 1; r = 4; end
            9'h01B: begin c = 1; r = 5; end
            9'h029: begin c = 2; r = 6; end
            9'h05A: begin c = 9; r = 4; end
            9'h076: begin c = 0; r = 7; end
            9'h005: begin c = 1; r = 7; end
            9'h066: begin c = 9; r = 5; end
            9'h175: begin c = 9; r = 3; end
            9'h172: begin c = 9; r = 2; end
            default: return 1'b0;
        endcase
        return 1'b1;
    endfunction

    function automatic int exp_view(input int c, input int r);
        if (r == 0 && c >= 2 && c <= 9) return int'(dip_sw[c-2]);
        return int'(model[c][r]);
    endfunction

    function automatic int exp_intr();
        for (int c = 0; c < 16; c++)
            for (int r = 1; r < 8; r++)
                if (model[c][r]) return 1;
        return 0;
    endfunction

    task automatic send_frame(input logic [7:0] b, input bit bad_par, input bit bad_stop);
        logic [10:0] f;
        f = {~bad_stop, (~^b) ^ bad_par, b, 1'b0};
        for (int i = 0; i < 11; i++) begin
            ps2_dat = f[i];
            cycles(5);
            ps2_clk = 1'b0;
            cycles(10);
            ps2_clk = 1'b1;
            cycles(5);
        end
        ps2_dat = 1'b1;
        cycles(30);
    endtask

    // Full key event; updates the model as the requirements state
    task automatic key_event(input bit ext, input logic [7:0] code, input bit release_it);
        int c, r;
        if (ext) send_frame(8'hE0, 0, 0);
        if (release_it) send_frame(8'hF0, 0, 0);
        send_frame(code, 0, 0);
        if (!ext && code == 8'h07) model_brk = !release_it;
        else if (pos_of(ext, code, c, r)) model[c][r] = !release_it;
    endtask

    task automatic read_key(input int c, input int r, output int v);
        col_sel = 4'(c);
        row_sel = 3'(r);
        cycles(1);
        v = int'(keypress);
    endtask

    task automatic check_key(input string req, input int c, input int r);
        int v;
        read_key(c, r, v);
        chk(req, v, exp_view(c, r));
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int v;
        void'($urandom(32'd2417));
        for (int c = 0; c < 16; c++) for (int r = 0; r < 8; r++) model[c][r] = 1'b0;
        cycles(4);
        rst_n = 1'b1;
        cycles(2);

        // R1: reset state
        chk("R1 scan_col", int'(scan_col), 0);
        chk("R1 intr", int'(intr), 0);
        chk("R1 brk", int'(brk), 0);
        check_key("R1 key 0/1", 0, 1);

        // R2 / R8: make a row 1 key
        key_event(0, 8'h15, 0);
        check_key("R2 make 0x15", 0, 1);
        chk("R8 intr row1", int'(intr), 1);
        // R4: release it
        key_event(0, 8'h15, 1);
        check_key("R4 release 0x15", 0, 1);
        chk("R4 intr cleared", int'(intr), 0);

        // R8: row 0 key does not interrupt
        key_event(0, 8'h12, 0);
        check_key("R8 row0 key held", 0, 0);
        chk("R8 row0 no intr", int'(intr), 0);
        key_event(0, 8'h12, 1);

        // R3: corrupted frames ignored
        send_frame(8'h1C, 1, 0);
        check_key("R3 bad parity", 1, 4);
        chk("R3 bad parity intr", int'(intr), 0);
        send_frame(8'h1C, 0, 1);
        check_key("R3 bad stop", 1, 4);
        key_event(0, 8'h1C, 0);
        check_key("R3 good after bad", 1, 4);
        key_event(0, 8'h1C, 1);

        // R5: extended codes
        send_frame(8'h75, 0, 0);
        check_key("R5 plain 0x75 ignored", 9, 3);
        chk("R5 plain ignored intr", int'(intr), 0);
        key_event(1, 8'h75, 0);
        check_key("R5 E0 75 make", 9, 3);
        key_event(1, 8'h75, 1);
        check_key("R5 E0 F0 75 release", 9, 3);

        // R9: switches on row 0 columns 2..9
        dip_sw = 8'b1010_0101;
        for (int i = 0; i < 8; i++) check_key("R9 dip bit", 2 + i, 0);
        chk("R9 dip no intr", int'(intr), 0);
        dip_sw = 8'b0101_1010;
        check_key("R9 dip changed", 3, 0);

        // R10: break key
        key_event(0, 8'h07, 0);
        chk("R10 brk set", int'(brk), 1);
        chk("R10 brk no intr", int'(intr), 0);
        key_event(0, 8'h07, 1);
        chk("R10 brk cleared", int'(brk), 0);

        // R7: column follow and autoscan stepping
        col_sel = 4'd5;
        cycles(2);
        chk("R7 follow col_sel", int'(scan_col), 5);
        key_event(0, 8'h5A, 0);
        autoscan = 1'b1;
        for (int i = 0; i < 13; i++) begin
            tick_1mhz = 1'b1;
            cycles(1);
            tick_1mhz = 1'b0;
            cycles(2);
        end
        chk("R7 autoscan wrap", int'(scan_col), 2);
        col_sel = 4'd9; row_sel = 3'd4;
        cycles(1);
        chk("R6 keypress quiet in autoscan", int'(keypress), 0);
        autoscan = 1'b0;
        check_key("R6 keypress back", 9, 4);
        key_event(0, 8'h5A, 1);

        // Random key traffic against the model (R2 R4 R5 R6 R8)
        for (int it = 0; it < 40; it++) begin
            logic [7:0] codes [14];
            int k;
            bit ext;
            codes = '{8'h15, 8'h26, 8'h25, 8'h1C, 8'h1B, 8'h29, 8'h5A,
                      8'h76, 8'h05, 8'h66, 8'h12, 8'h14, 8'h75, 8'h72};
            k = int'($urandom_range(13));
            ext = (k >= 12);
            key_event(ext, codes[k], $urandom_range(1) == 1);
            check_key("R6 random read", int'($urandom_range(15)), int'($urandom_range(7)));
            chk("R8 random intr", int'(intr), exp_intr());
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule